// File: doc/BRIEF.md
# SRAM Write Timing Monitor

This block watches the pins of an asynchronous byte-wide static RAM bus: an active-low select, an active-high select, an active-low write strobe, the address and the data. It samples them with a fast clock. It drives nothing onto the bus. From the three strobes it rebuilds the effective write window, and it measures in sample periods how long the window, the select and the address and data stay in place around it. Every minimum is a parameter given as a number of samples. Each rule that is broken sets its own sticky flag. The violation counter goes up, and an error pulse appears for one clock.

All measurements are taken at the sample clock. The monitor treats each sampled bus state as one unit of time. A rule is charged in the sample where its breach becomes certain. The flags, the counter and the pulse are registered on the clock edge that takes that sample.

Top module: `sram_wr_timing_monitor`

## Requirements
- R1: After reset the flags, the counter and the error pulse are all zero.
- R2: A sample lies inside the write window when the active-low select is low, the active-high select is high and the write strobe is low. The window therefore opens on whichever of the three arrives last and closes on whichever leaves first. Either select may be the one that opens or closes it.
- R3: Flag bit 0 (pulse width) is set in the closing sample when the window lasted fewer than MIN_WP samples. A window present in only one sample is always charged, whatever MIN_WP is.
- R4: Flag bit 1 (select to end) is set in the closing sample when both selects had been active together for fewer than MIN_SEL consecutive samples up to the close.
- R5: Flag bit 2 (address setup) is set in the opening sample when the address had been unchanged for fewer than MIN_ASU samples before it.
- R6: Flag bit 3 (address stability) is set when the address changes in a sample inside an open window after its first sample, in the closing sample, or in any of the next MIN_WR-1 samples after the close.
- R7: Flag bit 4 (data setup) is set in the closing sample when the data had been held over fewer than MIN_DSU samples up to the last window sample. A data change in the closing sample itself is allowed.
- R8: Flag bit 5 (cycle time) is set on an address change that comes fewer than MIN_CYC samples after the previous change, but only if a write window was active since that previous change. Address changes without a write are never charged.
- R9: Flags accumulate until cleared. The error pulse is high for exactly the clock after a sample that broke at least one rule. The counter adds the number of rules broken in that sample, saturating at its maximum.
- R10: A high clear input empties the flags and the counter. A violation found in the same sample is still recorded after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of flags and counter |
| bus_sel_n | input | 1 | Observed active-low select |
| bus_sel | input | 1 | Observed active-high select |
| bus_we_n | input | 1 | Observed active-low write strobe |
| bus_addr | input | AW | Observed address |
| bus_data | input | DW | Observed data |
| err_flags | output | 6 | Sticky per-rule flags, bit order as in R3 to R8 |
| viol_count | output | CW | Saturating count of rule breaches |
| err_pulse | output | 1 | High for one clock after a breaching sample |

## Verification
The clear input and the recording of a fresh violation can meet in one sample. The bench first leaves one charged pulse-width breach standing. It then asserts clear in the very sample that closes a second window that is too short. After that edge only bit 0 may be set and the counter must read one: neither the earlier total nor zero is accepted. A second collision is also provoked. An address change inside the window breaks both the stability rule and the cycle rule at once, so the counter must advance by two in a single clock.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;

  localparam int unsigned NRULE    = 6;
  localparam int unsigned RULE_WP  = 0;  // pulse width
  localparam int unsigned RULE_SEL = 1;  // select to end of write
  localparam int unsigned RULE_ASU = 2;  // address setup
  localparam int unsigned RULE_AST = 3;  // address stability
  localparam int unsigned RULE_DSU = 4;  // data setup
  localparam int unsigned RULE_CYC = 5;  // write cycle time

  // a measured span in samples falls short of its minimum
  function automatic logic below_min(input int unsigned measured,
                                     input int unsigned minimum);
    return measured < minimum;
  endfunction

  // a one-sample window is never acceptable
  function automatic int unsigned wp_floor(input int unsigned min_wp);
    return (min_wp < 2) ? 2 : min_wp;
  endfunction

  // age counts earlier equal samples; the span includes the present one
  function automatic int unsigned span_to_now(input int unsigned age_before);
    return age_before + 1;
  endfunction

  // saturating age step, zero on a change
  function automatic int unsigned next_age(input logic changed,
                                           input int unsigned prev,
                                           input int unsigned cap);
    if (changed) return 0;
    return (prev >= cap) ? cap : prev + 1;
  endfunction

endpackage

// File: rtl/sram_mon_age.sv
module sram_mon_age import sram_mon_pkg::*; #(
  parameter int unsigned W  = 8,
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  value,
  output logic          changed,
  output logic [TW-1:0] age_prev
);
  localparam int unsigned AGE_CAP = (32'd1 << TW) - 32'd1;

  logic [W-1:0]  val_q;
  logic [TW-1:0] age_q;

  assign changed  = (value != val_q);
  assign age_prev = age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      age_q <= '0;
    end else begin
      val_q <= value;
      age_q <= TW'(next_age(changed, 32'(age_q), AGE_CAP));
    end
  end
endmodule

// File: rtl/sram_mon_window.sv
module sram_mon_window #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          sel_hi,
  input  logic          we_n,
  output logic          win,
  output logic          opened,
  output logic          closed,
  output logic [TW-1:0] win_len,
  output logic [TW-1:0] sel_len
);
  localparam logic [TW-1:0] LEN_MAX = '1;

  logic          sel_on;
  logic          win_q;
  logic [1:0]    level;
  logic [TW-1:0] run_q [2];

  assign sel_on = !sel_n && sel_hi;
  assign win    = sel_on && !we_n;
  assign opened = win && !win_q;
  assign closed = !win && win_q;
  assign level  = {sel_on, win};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win;
  end

  // run length of each active level, saturating
  for (genvar g = 0; g < 2; g++) begin : g_run
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 run_q[g] <= '0;
      else if (!level[g])         run_q[g] <= '0;
      else if (run_q[g] != LEN_MAX) run_q[g] <= run_q[g] + 1'b1;
    end
  end

  assign win_len = run_q[0];
  assign sel_len = run_q[1];
endmodule

// File: rtl/sram_mon_guard.sv
module sram_mon_guard #(
  parameter int unsigned TW     = 8,
  parameter int unsigned MIN_WR = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win,
  input  logic opened,
  input  logic closed,
  output logic guard
);
  localparam int unsigned   REC_LOAD   = (MIN_WR > 0) ? MIN_WR - 1 : 0;
  localparam logic [TW-1:0] REC_LOAD_V = TW'(REC_LOAD);
  localparam logic          HAS_REC    = (MIN_WR > 0);

  logic [TW-1:0] rec_q;

  assign guard = (win && !opened) || (closed && HAS_REC) || (rec_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rec_q <= '0;
    else if (closed)       rec_q <= REC_LOAD_V;
    else if (rec_q != '0)  rec_q <= rec_q - 1'b1;
  end
endmodule

// File: rtl/sram_mon_accum.sv
module sram_mon_accum #(
  parameter int unsigned NR = 6,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [NR-1:0] fire,
  output logic [NR-1:0] flags,
  output logic [CW-1:0] count,
  output logic          pulse
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] base,
                                            input int unsigned inc);
    logic [CW:0] sum;
    sum = {1'b0, base} + (CW+1)'(inc);
    return sum[CW] ? CNT_MAX : sum[CW-1:0];
  endfunction

  int unsigned hits;
  always_comb hits = $countones(fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      count <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= |fire;
      if (clr) begin
        flags <= fire;
        count <= sat_add('0, hits);
      end else begin
        flags <= flags | fire;
        count <= sat_add(count, hits);
      end
    end
  end
endmodule

// File: rtl/sram_wr_timing_monitor.sv
module sram_wr_timing_monitor import sram_mon_pkg::*; #(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 8,
  parameter int unsigned TW      = 8,
  parameter int unsigned CW      = 16,
  parameter int unsigned MIN_WP  = 14,
  parameter int unsigned MIN_SEL = 15,
  parameter int unsigned MIN_ASU = 0,
  parameter int unsigned MIN_WR  = 0,
  parameter int unsigned MIN_DSU = 8,
  parameter int unsigned MIN_CYC = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bus_sel_n,
  input  logic             bus_sel,
  input  logic             bus_we_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  output logic [NRULE-1:0] err_flags,
  output logic [CW-1:0]    viol_count,
  output logic             err_pulse
);
  localparam int unsigned AGE_CAP = (32'd1 << TW) - 32'd1;

  // named internal events, also seen by the bound checker
  logic          win, opened, closed, guard;
  logic [TW-1:0] win_len, sel_len;
  logic          a_chg, d_chg;
  logic [TW-1:0] a_age_prev, d_age_prev;
  int unsigned   a_age_now;
  logic          seen_q, wrote_q;
  logic [NRULE-1:0] fire;

  sram_mon_window #(.TW(TW)) u_win (
    .clk(clk), .rst_n(rst_n),
    .sel_n(bus_sel_n), .sel_hi(bus_sel), .we_n(bus_we_n),
    .win(win), .opened(opened), .closed(closed),
    .win_len(win_len), .sel_len(sel_len)
  );

  sram_mon_age #(.W(AW), .TW(TW)) u_addr_age (
    .clk(clk), .rst_n(rst_n), .value(bus_addr),
    .changed(a_chg), .age_prev(a_age_prev)
  );

  sram_mon_age #(.W(DW), .TW(TW)) u_data_age (
    .clk(clk), .rst_n(rst_n), .value(bus_data),
    .changed(d_chg), .age_prev(d_age_prev)
  );

  sram_mon_guard #(.TW(TW), .MIN_WR(MIN_WR)) u_guard (
    .clk(clk), .rst_n(rst_n), .win(win),
    .opened(opened), .closed(closed), .guard(guard)
  );

  assign a_age_now = next_age(a_chg, 32'(a_age_prev), AGE_CAP);

  // cycle bookkeeping: a previous change exists, and a write lay between
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      wrote_q <= 1'b0;
    end else begin
      if (a_chg) seen_q <= 1'b1;
      if (a_chg)    wrote_q <= win;
      else if (win) wrote_q <= 1'b1;
    end
  end

  always_comb begin
    fire = '0;
    fire[RULE_WP]  = closed && below_min(32'(win_len), wp_floor(MIN_WP));
    fire[RULE_SEL] = closed && below_min(32'(sel_len), MIN_SEL);
    fire[RULE_ASU] = opened && below_min(a_age_now, MIN_ASU);
    fire[RULE_AST] = a_chg && guard;
    fire[RULE_DSU] = closed && below_min(span_to_now(32'(d_age_prev)), MIN_DSU);
    fire[RULE_CYC] = a_chg && seen_q && wrote_q &&
                     below_min(span_to_now(32'(a_age_prev)), MIN_CYC);
  end

  sram_mon_accum #(.NR(NRULE), .CW(CW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fire(fire),
    .flags(err_flags), .count(viol_count), .pulse(err_pulse)
  );
endmodule

// File: rtl/sram_mon_checker.sv
module sram_mon_checker import sram_mon_pkg::*; #(
  parameter int unsigned NR      = 6,
  parameter int unsigned CW      = 16,
  parameter int unsigned MIN_DSU = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          win,
  input logic          opened,
  input logic          closed,
  input logic          d_chg,
  input logic [NR-1:0] fire,
  input logic [NR-1:0] err_flags,
  input logic [CW-1:0] viol_count,
  input logic          err_pulse
);
  localparam logic DSU_TIGHT = (MIN_DSU > 1);

  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  a_r9_pulse_follows_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire) |=> err_pulse);

  a_r9_quiet_without_fire: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fire) |=> !err_pulse);

  a_r9_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (viol_count >= $past(viol_count)));

  a_r10_clear_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_flags == $past(fire)));

  a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(opened && closed));

  a_r3_single_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (closed && $past(opened)) |-> fire[RULE_WP]);

  a_r7_late_data: assert property (@(posedge clk) disable iff (!rst_n)
    (DSU_TIGHT && win && d_chg) |=> (closed |-> fire[RULE_DSU]));
endmodule

bind sram_wr_timing_monitor sram_mon_checker #(
  .NR(sram_mon_pkg::NRULE), .CW(CW), .MIN_DSU(MIN_DSU)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .win(win),
  .opened(opened), .closed(closed), .d_chg(d_chg), .fire(fire),
  .err_flags(err_flags), .viol_count(viol_count), .err_pulse(err_pulse)
);

// File: tb/tb_sram_wr_timing_monitor.sv
module tb_sram_wr_timing_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       bus_sel_n = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_we_n = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_data = 8'h00;
  logic [5:0] err_flags;
  logic [7:0] viol_count;
  logic       err_pulse;

  always #2 clk = ~clk;  // 250 MHz

  sram_wr_timing_monitor #(
    .AW(8), .DW(8), .TW(8), .CW(8),
    .MIN_WP(4), .MIN_SEL(6), .MIN_ASU(2), .MIN_WR(2), .MIN_DSU(3), .MIN_CYC(10)
  ) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .bus_sel_n(bus_sel_n), .bus_sel(bus_sel), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .err_flags(err_flags), .viol_count(viol_count), .err_pulse(err_pulse)
  );

  // bit order per R3..R8
  localparam logic [5:0] F_WP  = 6'b000001;
  localparam logic [5:0] F_SEL = 6'b000010;
  localparam logic [5:0] F_ASU = 6'b000100;
  localparam logic [5:0] F_AST = 6'b001000;
  localparam logic [5:0] F_DSU = 6'b010000;
  localparam logic [5:0] F_CYC = 6'b100000;

  typedef struct {
    int         at;
    string      req;
    logic [5:0] flags;
    logic       pulse;
    logic [7:0] count;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] cur_a = 8'h00;
  logic [7:0] cur_d = 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares after the sampling edge has settled
  always @(posedge clk) begin
    #1;
    while (sbq.size() > 0 && sbq[0].at == cyc) begin
      item_t it;
      it = sbq.pop_front();
      n_cmp++;
      if (err_flags !== it.flags || err_pulse !== it.pulse || viol_count !== it.count) begin
        n_bad++;
        $display("FAIL %s: flags=%b exp %b, pulse=%b exp %b, count=%0d exp %0d",
                 it.req, err_flags, it.flags, err_pulse, it.pulse, viol_count, it.count);
      end
    end
  end

  task automatic step(input logic sn, input logic sh, input logic wn,
                      input logic [7:0] a, input logic [7:0] d, input logic c);
    @(negedge clk);
    bus_sel_n = sn; bus_sel = sh; bus_we_n = wn;
    bus_addr = a; bus_data = d; clr = c;
    cur_a = a; cur_d = d;
  endtask

  // expectation for the sample just driven
  task automatic want(input string req, input logic [5:0] f,
                      input logic p, input logic [7:0] n);
    item_t it;
    it.at = cyc + 1; it.req = req; it.flags = f; it.pulse = p; it.count = n;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b1, cur_a, cur_d, 1'b0);
  endtask

  task automatic clear_all(input string req);
    idle(12);
    step(1'b1, 1'b0, 1'b1, cur_a, cur_d, 1'b1);
    want(req, 6'b0, 1'b0, 8'd0);
  endtask

  // write opened by the write strobe; expectation at the closing sample
  task automatic wr(input logic [7:0] a, input logic [7:0] d, input int pre,
                    input int width, input int post, input logic clr_close,
                    input string req, input logic [5:0] ef, input logic ep,
                    input logic [7:0] en);
    for (int i = 0; i < pre; i++)   step(1'b0, 1'b1, 1'b1, a, d, 1'b0);
    for (int i = 0; i < width; i++) step(1'b0, 1'b1, 1'b0, a, d, 1'b0);
    step(1'b1, 1'b0, 1'b1, a, d, clr_close);
    want(req, ef, ep, en);
    idle(post - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    want("R1 reset state", 6'b0, 1'b0, 8'd0);

    // R2 legal writes; second one also sits exactly on the R8 cycle boundary
    wr(8'h11, 8'hA1, 3, 4, 3, 1'b0, "R2 legal write", 6'b0, 1'b0, 8'd0);
    wr(8'h22, 8'hA2, 3, 4, 3, 1'b0, "R8 cycle at minimum", 6'b0, 1'b0, 8'd0);

    // R3 short window opened by the write strobe
    wr(8'h33, 8'hA3, 5, 2, 3, 1'b0, "R3 short pulse", F_WP, 1'b1, 8'd1);
    clear_all("R10 clear");

    // R3 single-sample window, then R10 clear meeting a new breach
    wr(8'h44, 8'hA4, 5, 1, 4, 1'b0, "R3 one-sample window", F_WP, 1'b1, 8'd1);
    wr(8'h55, 8'hA5, 5, 2, 3, 1'b1, "R10 clear with violation", F_WP, 1'b1, 8'd1);
    clear_all("R10 clear");

    // R4 window opened and closed by the active-low select
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 8'h66, 8'hB0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 8'h66, 8'hB0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 8'h66, 8'hB0, 1'b0);
    want("R4 select too short", F_SEL, 1'b1, 8'd1);
    idle(1);

    // R2 window opened and closed by the active-high select
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 8'h77, 8'hB1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 8'h77, 8'hB1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 8'h77, 8'hB1, 1'b0);
    want("R2 high select window", F_SEL, 1'b1, 8'd2);
    idle(1);
    clear_all("R10 clear");

    // R5 address changes one sample before the opening
    step(1'b0, 1'b1, 1'b1, 8'h88, 8'hB2, 1'b0);
    step(1'b0, 1'b1, 1'b0, 8'h88, 8'hB2, 1'b0);
    want("R5 setup short", F_ASU, 1'b1, 8'd1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 8'h88, 8'hB2, 1'b0);
    step(1'b1, 1'b0, 1'b1, 8'h88, 8'hB2, 1'b0);
    want("R5 close after setup breach", F_ASU, 1'b0, 8'd1);
    idle(3);
    wr(8'h99, 8'hB3, 2, 4, 4, 1'b0, "R5 setup at minimum", F_ASU, 1'b0, 8'd1);
    clear_all("R10 clear");

    // R6 address moves inside the window: stability and cycle in one sample
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 8'hAA, 8'hC0, 1'b0);
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b0, 8'hAA, 8'hC0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 8'hAB, 8'hC0, 1'b0);
    want("R6 change in window", F_AST | F_CYC, 1'b1, 8'd2);
    step(1'b0, 1'b1, 1'b0, 8'hAB, 8'hC0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 8'hAB, 8'hC0, 1'b0);
    want("R6 close after change", F_AST | F_CYC, 1'b0, 8'd2);
    idle(14);
    clear_all("R10 clear");

    // R6 address moves during recovery
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 8'hBB, 8'hC1, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 8'hBB, 8'hC1, 1'b0);
    step(1'b1, 1'b0, 1'b1, 8'hBB, 8'hC1, 1'b0);
    step(1'b1, 1'b0, 1'b1, 8'hBC, 8'hC1, 1'b0);
    want("R6 change in recovery", F_AST | F_CYC, 1'b1, 8'd2);
    idle(14);
    clear_all("R10 clear");

    // R7 data changes late in the window, then at the limit
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 8'hCC, 8'h01, 1'b0);
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b0, 8'hCC, 8'h01, 1'b0);
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b0, 8'hCC, 8'h02, 1'b0);
    step(1'b1, 1'b0, 1'b1, 8'hCC, 8'h02, 1'b0);
    want("R7 data setup short", F_DSU, 1'b1, 8'd1);
    idle(2);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 8'hCD, 8'h03, 1'b0);
    step(1'b0, 1'b1, 1'b0, 8'hCD, 8'h03, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 8'hCD, 8'h04, 1'b0);
    step(1'b1, 1'b0, 1'b1, 8'hCD, 8'h05, 1'b0);
    want("R7 data setup at minimum", F_DSU, 1'b0, 8'd1);
    clear_all("R10 clear");

    // R8 next address one sample too early
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 8'hDD, 8'hD0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 8'hDD, 8'hD0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 8'hDD, 8'hD0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 8'hDD, 8'hD0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 8'hDE, 8'hD0, 1'b0);
    want("R8 cycle short", F_CYC, 1'b1, 8'd1);
    idle(12);

    // R8 fast address changes with no write are not charged
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0, 1'b1, 8'hE0 + 8'(i), 8'hD0, 1'b0);
      want("R8 no write no charge", F_CYC, 1'b0, 8'd1);
    end

    idle(4);
    if (sbq.size() != 0) begin
      n_bad++;
      $display("FAIL R9 scoreboard: %0d expectations left, expected 0", sbq.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule